// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

The controller sits between eight interrupt request lines and a processor core. It registers each request on its rising edge, chooses one pending source to hand to the core, and keeps a stack of the priority levels whose service routines are in progress. The core takes a delivered source with a one-cycle acknowledge. It reports the end of the running routine with a one-cycle end-of-service strobe.

A mode input selects one of two policies. In sequential mode nothing new is delivered while any routine is active, so requests are serviced strictly one after another. In nested mode a pending request interrupts the running routine only when its priority is strictly above the active level. On every end of service the controller checks held requests against the restored level. A held request that outranks that level is therefore delivered before the resumed routine gets any further.

Level 0 stands for the user program. A source of priority p runs at level p+1, so every source outranks the user program.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A source's pending bit is set only by a 0-to-1 transition of its request line. A line held high after its acknowledge produces no second delivery.
- R2: The delivered source is the pending source with the highest priority (`prio_i[3*k+2:3*k]` for source k). Among equal priorities, the lowest index wins.
- R3: `take_o` stays high and `take_id_o` stays constant from the cycle delivery starts until the cycle `ack_i` is sampled high. At most one delivery is outstanding.
- R4: An acknowledge clears the delivered source's pending bit and pushes level priority+1. In the next cycle `active_lvl_o` shows that level and `depth_o` is one higher.
- R5: In sequential mode (`nest_mode_i`=0) no delivery starts while `depth_o` is non-zero. A request that arrives meanwhile is kept and delivered after the last end of service.
- R6: In nested mode (`nest_mode_i`=1), a request is delivered while a routine is active only if its level is strictly greater than `active_lvl_o`. Equal or lower requests are held.
- R7: `eos_i` pops the top level. A held request that outranks the restored level is delivered in the cycle after the pop, one register stage later.
- R8: With `depth_o`=0 (level 0, user program), any pending request is delivered.
- R9: An end of service with an empty stack, or a push onto a full stack, sets `err_o`. The stack is left unchanged, and `err_o` stays set until reset.
- R10: With sources at priorities 2, 4 and 5, the sequence is: low taken, high preempts, middle held, high ends, middle taken, middle ends, low resumes, low ends, level 0.
- R11: After reset, `take_o`, `active_lvl_o`, `depth_o` and `err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Request lines, rising-edge sensitive |
| prio_i | input | 24 | Per-source 3-bit priority, source k at bits 3k+2:3k |
| nest_mode_i | input | 1 | 1 = nested preemption, 0 = sequential |
| ack_i | input | 1 | Core accepts the delivered source |
| eos_i | input | 1 | Core ends the running routine |
| take_o | output | 1 | Delivery outstanding |
| take_id_o | output | 3 | Index of the delivered source |
| active_lvl_o | output | 4 | Current active level, 0 = user program |
| depth_o | output | 4 | Number of active routines |
| err_o | output | 1 | Sticky stack misuse flag |

## Verification
The bench aims at four situations:
- **End-of-service handoff.** A held request must be taken exactly one cycle after a pop. A design that skipped re-arbitration would let the resumed routine run first. A design that compared against the stale level would never deliver the request.
- **Equal-priority requests in nested mode.** They must be held. An off-by-one compare would nest a source on top of its own level.
- **Sequential mode.** It must hold off even a top-priority request while one routine is active, without dropping it.
- **Request lines left high, and misuse of an empty stack.** A level-sensitive pending bit would re-deliver the held line. A missing guard would wrap the depth counter.

Random traffic in both modes is compared cycle by cycle against a bench model.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SWAP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/nic_pend.sv
module nic_pend #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] irq_q, pend_q, rise;

  assign rise = irq_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      // a fresh edge in the clearing cycle is a new request and survives
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/nic_arb.sv
module nic_arb #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned ID_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    vld_o,
  output logic [ID_W-1:0]         id_o,
  output logic [PRIO_W-1:0]       prio_o
);
  logic [PRIO_W-1:0] prio_a [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
    assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
  end

  // scan downward with >= so the lowest index wins a tie
  always_comb begin
    vld_o  = 1'b0;
    id_o   = '0;
    prio_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && (!vld_o || prio_a[i] >= prio_o)) begin
        vld_o  = 1'b1;
        id_o   = ID_W'(i);
        prio_o = prio_a[i];
      end
    end
  end
endmodule

// File: rtl/nic_lvl_stack.sv
module nic_lvl_stack
  import nic_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0] top_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  logic [LVL_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             empty, full;
  logic [IDX_W-1:0] top_idx, nxt_idx;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = IDX_W'(cnt_q - 1'b1);
  assign nxt_idx = IDX_W'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      unique case (op_i)
        STK_PUSH: begin
          if (full) err_q <= 1'b1;
          else begin
            mem_q[nxt_idx] <= lvl_i;
            cnt_q          <= cnt_q + 1'b1;
          end
        end
        STK_POP: begin
          if (empty) err_q <= 1'b1;
          else cnt_q <= cnt_q - 1'b1;
        end
        STK_SWAP: begin
          // pop and push in one cycle: replace top
          if (empty) begin
            err_q    <= 1'b1;
            mem_q[0] <= lvl_i;
            cnt_q    <= CNT_W'(1);
          end else begin
            mem_q[top_idx] <= lvl_i;
          end
        end
        default: ;
      endcase
    end
  end

  assign top_o = empty ? '0 : mem_q[top_idx];
  assign cnt_o = cnt_q;
  assign err_o = err_q;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned ID_W  = $clog2(N_SRC),
  localparam int unsigned LVL_W = PRIO_W + 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        irq_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic                    nest_mode_i,
  input  logic                    ack_i,
  input  logic                    eos_i,
  output logic                    take_o,
  output logic [ID_W-1:0]         take_id_o,
  output logic [LVL_W-1:0]        active_lvl_o,
  output logic [CNT_W-1:0]        depth_o,
  output logic                    err_o
);
  logic [N_SRC-1:0]  pend, clr;
  logic              win_vld;
  logic [ID_W-1:0]   win_id;
  logic [PRIO_W-1:0] win_prio;
  logic [LVL_W-1:0]  win_lvl, cur_lvl;
  logic [CNT_W-1:0]  cnt;
  logic              allow, accept;
  stk_op_e           op;

  logic              take_q;
  logic [ID_W-1:0]   id_q;
  logic [LVL_W-1:0]  lvl_q;

  nic_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  nic_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend_i (pend),
    .prio_i (prio_i),
    .vld_o  (win_vld),
    .id_o   (win_id),
    .prio_o (win_prio)
  );

  nic_lvl_stack #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .lvl_i  (lvl_q),
    .top_o  (cur_lvl),
    .cnt_o  (cnt),
    .err_o  (err_o)
  );

  assign win_lvl = {1'b0, win_prio} + LVL_W'(1);
  assign accept  = take_q & ack_i;
  assign clr     = accept ? (N_SRC'(1) << id_q) : '0;

  // level 0 admits anything; nesting needs a strictly higher level
  assign allow = (cnt == '0) || (nest_mode_i && (win_lvl > cur_lvl));

  always_comb begin
    unique case ({accept, eos_i})
      2'b10:   op = STK_PUSH;
      2'b01:   op = STK_POP;
      2'b11:   op = STK_SWAP;
      default: op = STK_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      id_q   <= '0;
      lvl_q  <= '0;
    end else if (take_q) begin
      if (ack_i) take_q <= 1'b0;
    end else if (win_vld && allow) begin
      take_q <= 1'b1;
      id_q   <= win_id;
      lvl_q  <= win_lvl;
    end
  end

  assign take_o       = take_q;
  assign take_id_o    = id_q;
  assign active_lvl_o = cur_lvl;
  assign depth_o      = cnt;
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned ID_W  = $clog2(N_SRC),
  localparam int unsigned LVL_W = PRIO_W + 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC*PRIO_W-1:0] prio_i,
  input logic                    nest_mode_i,
  input logic                    ack_i,
  input logic                    eos_i,
  input logic                    take_o,
  input logic [ID_W-1:0]         take_id_o,
  input logic [LVL_W-1:0]        active_lvl_o,
  input logic [CNT_W-1:0]        depth_o,
  input logic                    err_o
);
  logic [LVL_W-1:0] tk_lvl;
  assign tk_lvl = {1'b0, prio_i[take_id_o*PRIO_W +: PRIO_W]} + LVL_W'(1);

  p_take_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !ack_i |=> take_o && $stable(take_id_o));

  p_ack_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && ack_i && !eos_i && depth_o != CNT_W'(DEPTH)
    |=> depth_o == $past(depth_o) + 1'b1 && active_lvl_o == $past(tk_lvl));

  p_seq_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o && !nest_mode_i && depth_o != '0 |=> !take_o);

  p_nest_strict_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o && nest_mode_i && depth_o != '0 ##1 take_o |-> tk_lvl > $past(active_lvl_o));

  p_eos_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_i && !(take_o && ack_i) && depth_o != '0 |=> depth_o == $past(depth_o) - 1'b1);

  p_pop_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_i && !(take_o && ack_i) && depth_o == '0 |=> err_o && depth_o == '0);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind nest_irq_ctrl nic_chk #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prio_i       (prio_i),
  .nest_mode_i  (nest_mode_i),
  .ack_i        (ack_i),
  .eos_i        (eos_i),
  .take_o       (take_o),
  .take_id_o    (take_id_o),
  .active_lvl_o (active_lvl_o),
  .depth_o      (depth_o),
  .err_o        (err_o)
);

// File: tb/nest_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq = '0;
  logic [23:0] prio;
  logic        nest = 1'b1;
  logic        ack = 1'b0;
  logic        eos = 1'b0;
  logic        take;
  logic [2:0]  take_id;
  logic [3:0]  lvl;
  logic [3:0]  depth;
  logic        err;

  logic [2:0]  prio_cfg [8];
  int          checks = 0;
  int          errors = 0;

  // reference model state
  logic [7:0]  m_pend, m_irq_prev;
  logic        m_take, m_err;
  logic [2:0]  m_id;
  logic [3:0]  m_lvl;
  logic [3:0]  m_stk [8];
  int          m_cnt;

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) prio[i*3 +: 3] = prio_cfg[i];

  nest_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .prio_i(prio), .nest_mode_i(nest),
    .ack_i(ack), .eos_i(eos), .take_o(take), .take_id_o(take_id),
    .active_lvl_o(lvl), .depth_o(depth), .err_o(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_top();
    return (m_cnt == 0) ? 0 : int'(m_stk[m_cnt-1]);
  endfunction

  // one clock edge of the model, from the requirement text
  task automatic model_tick();
    logic [7:0] rise, clr;
    logic       bv, acc;
    int         bi, bp;
    rise = irq & ~m_irq_prev;
    bv = 1'b0; bi = 0; bp = 0;
    for (int i = 0; i < 8; i++)
      if (m_pend[i] && (!bv || int'(prio_cfg[i]) > bp)) begin
        bv = 1'b1; bi = i; bp = int'(prio_cfg[i]);
      end
    acc = m_take && ack;
    clr = '0;
    if (acc) clr[m_id] = 1'b1;
    if (acc && eos) begin
      if (m_cnt == 0) begin m_err = 1'b1; m_stk[0] = m_lvl; m_cnt = 1; end
      else m_stk[m_cnt-1] = m_lvl;
    end else if (acc) begin
      if (m_cnt == 8) m_err = 1'b1;
      else begin m_stk[m_cnt] = m_lvl; m_cnt++; end
    end else if (eos) begin
      if (m_cnt == 0) m_err = 1'b1;
      else m_cnt--;
    end
    if (m_take) begin
      if (ack) m_take = 1'b0;
    end else if (bv && (m_cnt_prev_zero || (nest && bp + 1 > m_top_prev))) begin
      m_take = 1'b1; m_id = 3'(bi); m_lvl = 4'(bp + 1);
    end
    m_pend = (m_pend & ~clr) | rise;
    m_irq_prev = irq;
  endtask

  logic m_cnt_prev_zero;
  int   m_top_prev;

  task automatic step();
    m_cnt_prev_zero = (m_cnt == 0);
    m_top_prev = m_top();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    chk(nest ? "R6 take" : "R5 take", int'(take), int'(m_take));
    if (take && m_take) chk("R2 take_id", int'(take_id), int'(m_id));
    chk("R4 active_lvl", int'(lvl), m_top());
    chk("R4 depth", int'(depth), m_cnt);
    chk("R9 err", int'(err), int'(m_err));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; ack = 1'b0; eos = 1'b0;
    m_pend = '0; m_irq_prev = '0; m_take = 1'b0; m_err = 1'b0;
    m_id = '0; m_lvl = '0; m_cnt = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 take", int'(take), 0);
    chk("R11 lvl", int'(lvl), 0);
    chk("R11 depth", int'(depth), 0);
    chk("R11 err", int'(err), 0);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input int src);
    irq[src] = 1'b1;
    step();
    irq[src] = 1'b0;
  endtask

  task automatic wait_take(input int id, input int maxc, input string tag);
    int n = 0;
    while (!take && n < maxc) begin step(); n++; end
    chk(tag, int'(take), 1);
    chk(tag, int'(take_id), id);
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic end_service();
    eos = 1'b1; step(); eos = 1'b0;
  endtask

  task automatic idle_no_take(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step();
      chk(tag, int'(take), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 8; i++) prio_cfg[i] = 3'd0;

    // R10 scenario: src1 prio 2, src3 prio 4, src6 prio 5, nested
    prio_cfg[1] = 3'd2; prio_cfg[3] = 3'd4; prio_cfg[6] = 3'd5;
    nest = 1'b1;
    do_reset();
    pulse(1);
    wait_take(1, 3, "R10 low taken R8");
    chk("R10 lvl low", int'(lvl), 3);
    pulse(6);
    wait_take(6, 3, "R10 high preempts");
    chk("R10 lvl high", int'(lvl), 6);
    pulse(3);
    idle_no_take(5, "R10 middle held R6");
    end_service();
    chk("R7 no take in pop cycle", int'(take), 0);
    wait_take(3, 1, "R7 middle taken on return");
    chk("R10 lvl middle", int'(lvl), 5);
    chk("R10 depth middle", int'(depth), 2);
    end_service();
    chk("R10 low resumes", int'(lvl), 3);
    idle_no_take(3, "R10 nothing pending");
    end_service();
    chk("R10 user level", int'(lvl), 0);
    chk("R10 user depth", int'(depth), 0);

    // R2 tie and R6 equal level held
    for (int i = 0; i < 8; i++) prio_cfg[i] = 3'd0;
    prio_cfg[0] = 3'd3; prio_cfg[2] = 3'd5; prio_cfg[4] = 3'd5;
    irq = 8'b0001_0101; step(); irq = '0;
    wait_take(2, 3, "R2 tie lowest index");
    idle_no_take(4, "R6 equal level held");
    end_service();
    wait_take(4, 2, "R2 second of tie");
    end_service();
    wait_take(0, 2, "R2 lowest priority last");
    end_service();

    // R5 sequential hold-off
    nest = 1'b0;
    prio_cfg[5] = 3'd1; prio_cfg[7] = 3'd6;
    pulse(5);
    wait_take(5, 3, "R5 first taken");
    pulse(7);
    idle_no_take(6, "R5 blocked while active");
    end_service();
    wait_take(7, 2, "R5 kept and delivered");
    end_service();
    chk("R5 depth back to 0", int'(depth), 0);

    // R1 level held high gives one delivery
    nest = 1'b1;
    prio_cfg[2] = 3'd4;
    irq[2] = 1'b1;
    step();
    wait_take(2, 3, "R1 edge delivers");
    end_service();
    idle_no_take(5, "R1 held line no repeat");
    chk("R1 depth", int'(depth), 0);
    irq[2] = 1'b0;
    step();

    // R9 pop on empty stack
    end_service();
    chk("R9 err set", int'(err), 1);
    chk("R9 depth unchanged", int'(depth), 0);
    idle_no_take(3, "R9 idle after error");
    chk("R9 err sticky", int'(err), 1);

    // random traffic checked against the model
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 8; i++) prio_cfg[i] = 3'($urandom_range(0, 7));
      nest = ph[0];
      do_reset();
      for (int c = 0; c < 3000; c++) begin
        for (int b = 0; b < 8; b++)
          if ($urandom_range(0, 15) == 0) irq[b] = ~irq[b];
        ack = take && ($urandom_range(0, 1) == 1);
        eos = (depth != 0) && ($urandom_range(0, 5) == 0);
        step();
      end
      ack = 1'b0; eos = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule